// File: doc/BRIEF.md
# Dual-Channel Recursive Sine Oscillator

This block produces two sine-wave sample streams that share one frequency and differ by a phase offset the host chooses. No lookup table is used. Each channel runs a second-order recurrence on its two most recent samples: the new sample is the frequency coefficient times the newest sample, minus the older sample. The coefficient equals twice the cosine of the phase step per sample. The host works out the trigonometry. The block only iterates.

The host first writes one shared coefficient and a pair of seed samples for each channel with a load strobe, then raises a start strobe. After that, every pulse on the sample-tick input makes the block compute one new sample per channel. A single multiplier serves both channels in turn. Once both results exist, the two histories advance together and a one-cycle valid pulse is raised. The seeds alone set each channel's phase and amplitude, so any offset from 0 to 360 degrees, and any amplitude, comes from how the seeds are chosen. A 2 kHz tone at a 40 kHz tick rate (20 samples per period), with a 60 degree offset between the channels, is the reference use.

Top module: `dual_sine_osc`

## Requirements
- R1: While reset is held and after it is released, sampleA, sampleB, sampleValid and running are all 0.
- R2: A load strobe captures coefIn and the four seeds. On the next cycle sampleA equals seedANew, sampleB equals seedBNew, and running is 0.
- R3: Each new sample is computed from the coefficient c, read as signed Q2.14, and the channel's newest (yN) and older (yO) samples as sat((c*yN - yO*16384 + 8192) >>> 14), using an arithmetic shift. Halves therefore round upward (1.5 gives 2, -1.5 gives -1).
- R4: A result above 32767 is clamped to 32767, and a result below -32768 is clamped to -32768. Wrap-around never occurs.
- R5: A tick is accepted only while running and no computation is in progress. For a tick sampled at clock edge t, sampleValid is high for exactly one cycle, starting at edge t+2. Ticks sampled while a computation is in progress are ignored. The samples change only when sampleValid rises or after a load.
- R6: Both channels use the same coefficient, and both samples are updated on the same sampleValid pulse.
- R7: A start strobe sets running. Ticks received while running is 0 produce no sampleValid and leave both samples unchanged.
- R8: A load strobe during a computation abandons it: no sampleValid follows, the new seeds appear, and running returns to 0. A load in the same cycle as a start wins, so running stays 0.
- R9: After each update, the old newest sample becomes the channel's older sample and the result becomes its newest, so successive outputs follow the recurrence.
- R10: With c = 31164 (a step of 18 degrees), channel A seeded (yN=0, yO=-4944) and channel B seeded (yN=13856, yO=10706), the samples after 20 ticks are within 64 of 0 and 13856 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Capture the coefficient and seeds, and halt |
| startStb | input | 1 | Begin accepting ticks |
| tick | input | 1 | Sample-period strobe |
| coefIn | input | 16 | Shared coefficient, signed Q2.14 |
| seedANew | input | 16 | Channel A newest seed, y(n-1) |
| seedAOld | input | 16 | Channel A older seed, y(n-2) |
| seedBNew | input | 16 | Channel B newest seed |
| seedBOld | input | 16 | Channel B older seed |
| sampleA | output | 16 | Channel A current sample |
| sampleB | output | 16 | Channel B current sample |
| sampleValid | output | 1 | One-cycle pulse when new samples are presented |
| running | output | 1 | Ticks are being accepted |

## Verification
The assertions take it that each tick is a single-cycle pulse. The check that a valid pulse follows a tick three edges later depends on this. The stimulus therefore raises tick for one cycle at a time, except in the R5 case, where a held tick falls entirely inside a computation that is already in progress. The bench's reference model applies the recurrence to integers at every clock and compares both samples and the valid pulse. Directed seeds drive the rounding ties, both saturation limits, an abort by load in mid-computation, and the 20-sample period of the reference tone.

// File: rtl/sine_osc_pkg.sv
package sine_osc_pkg;
  localparam int NUM_CH   = 2;
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic                load;
    logic                mulEn;
    logic                commit;
    logic [CH_IDX_W-1:0] chSel;
  } oscStrobe_t;
endpackage

// File: rtl/sine_osc_ctrl.sv
module sine_osc_ctrl
  import sine_osc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStb,
  input  logic       startStb,
  input  logic       tick,
  output oscStrobe_t strobe,
  output logic       running
);
  localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NUM_CH - 1);

  logic                runQ;
  logic                busyQ;
  logic [CH_IDX_W-1:0] chCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      busyQ <= 1'b0;
      chCnt <= '0;
    end else if (loadStb) begin
      runQ  <= 1'b0;
      busyQ <= 1'b0;
      chCnt <= '0;
    end else begin
      if (busyQ) begin
        if (chCnt == LAST_CH) begin
          busyQ <= 1'b0;
          chCnt <= '0;
        end else begin
          chCnt <= chCnt + 1'b1;
        end
      end else if (tick && runQ) begin
        busyQ <= 1'b1;
        chCnt <= '0;
      end
      if (startStb) runQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.load   = loadStb;
    strobe.mulEn  = busyQ && !loadStb;
    strobe.chSel  = chCnt;
    strobe.commit = busyQ && !loadStb && (chCnt == LAST_CH);
  end

  assign running = runQ;
endmodule

// File: rtl/sine_osc_dp.sv
module sine_osc_dp
  import sine_osc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  oscStrobe_t               strobe,
  input  logic signed [COEF_W-1:0] coefIn,
  input  logic signed [DATA_W-1:0] seedNew [NUM_CH],
  input  logic signed [DATA_W-1:0] seedOld [NUM_CH],
  output logic signed [DATA_W-1:0] sampleOut [NUM_CH],
  output logic                     validOut
);
  localparam int PROD_W = COEF_W + DATA_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam longint MAX_L = (64'sd1 <<< (DATA_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(MAX_L);
  localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-MAX_L - 1);
  localparam logic signed [ACC_W-1:0] RND_C  = ACC_W'(64'sd1 <<< (COEF_FRAC - 1));

  logic signed [COEF_W-1:0] coefQ;
  logic signed [DATA_W-1:0] newVec [NUM_CH];
  logic signed [DATA_W-1:0] oldVec [NUM_CH];
  logic signed [DATA_W-1:0] selNew, selOld, satOut;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, rnd;
  logic                     validQ;

  always_ff @(posedge clk) begin
    if (!rstN)            coefQ <= '0;
    else if (strobe.load) coefQ <= coefIn;
  end

  // shared multiplier, one channel per cycle
  always_comb begin
    selNew = newVec[strobe.chSel];
    selOld = oldVec[strobe.chSel];
    prod   = coefQ * selNew;
    acc    = ACC_W'(prod) - (ACC_W'(selOld) <<< COEF_FRAC);
    rnd    = (acc + RND_C) >>> COEF_FRAC;
    if (rnd > SAT_HI)      satOut = DATA_W'(SAT_HI);
    else if (rnd < SAT_LO) satOut = DATA_W'(SAT_LO);
    else                   satOut = DATA_W'(rnd);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic signed [DATA_W-1:0] yNew, yOld, resHold;
    logic                     selHit;
    assign selHit = (strobe.chSel == CH_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        yNew    <= '0;
        yOld    <= '0;
        resHold <= '0;
      end else if (strobe.load) begin
        yNew <= seedNew[g];
        yOld <= seedOld[g];
      end else if (strobe.commit) begin
        yOld <= yNew;
        yNew <= selHit ? satOut : resHold;
      end else if (strobe.mulEn && selHit) begin
        resHold <= satOut;
      end
    end

    assign newVec[g]    = yNew;
    assign oldVec[g]    = yOld;
    assign sampleOut[g] = yNew;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobe.commit;
  end
  assign validOut = validQ;
endmodule

// File: rtl/dual_sine_osc.sv
module dual_sine_osc
  import sine_osc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadStb,
  input  logic                     startStb,
  input  logic                     tick,
  input  logic signed [COEF_W-1:0] coefIn,
  input  logic signed [DATA_W-1:0] seedANew,
  input  logic signed [DATA_W-1:0] seedAOld,
  input  logic signed [DATA_W-1:0] seedBNew,
  input  logic signed [DATA_W-1:0] seedBOld,
  output logic signed [DATA_W-1:0] sampleA,
  output logic signed [DATA_W-1:0] sampleB,
  output logic                     sampleValid,
  output logic                     running
);
  oscStrobe_t               strobe;
  logic signed [DATA_W-1:0] seedNewVec [NUM_CH];
  logic signed [DATA_W-1:0] seedOldVec [NUM_CH];
  logic signed [DATA_W-1:0] outVec     [NUM_CH];

  assign seedNewVec[0] = seedANew;
  assign seedNewVec[1] = seedBNew;
  assign seedOldVec[0] = seedAOld;
  assign seedOldVec[1] = seedBOld;

  sine_osc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .startStb(startStb),
    .tick(tick), .strobe(strobe), .running(running)
  );

  sine_osc_dp #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coefIn(coefIn),
    .seedNew(seedNewVec), .seedOld(seedOldVec),
    .sampleOut(outVec), .validOut(sampleValid)
  );

  assign sampleA = outVec[0];
  assign sampleB = outVec[1];
endmodule

// File: rtl/dual_sine_osc_chk.sv
module dual_sine_osc_chk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     loadStb,
  input logic                     startStb,
  input logic                     tick,
  input logic signed [DATA_W-1:0] seedANew,
  input logic signed [DATA_W-1:0] seedBNew,
  input logic signed [DATA_W-1:0] sampleA,
  input logic signed [DATA_W-1:0] sampleB,
  input logic                     sampleValid,
  input logic                     running
);
  // R5: valid lasts one cycle
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R5: valid comes from a tick three edges earlier
  a_r5_tick_to_valid: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(tick, 3));

  // R5: samples hold between updates
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !sampleValid && !$past(loadStb)) |-> ($stable(sampleA) && $stable(sampleB)));

  // R8: load halts and suppresses valid, even beside a start
  a_r8_load_halts: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (!running && !sampleValid));

  // R2: loaded seeds appear on the outputs
  a_r2_seed_shown: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(loadStb)) |-> (sampleA == $past(seedANew) && sampleB == $past(seedBNew)));

  // R7: no valid while halted
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !sampleValid);

  // R7: start leads to running
  a_r7_start: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && !loadStb) |=> running);
endmodule

bind dual_sine_osc dual_sine_osc_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dual_sine_osc_bench.sv
module dual_sine_osc_bench;
  logic clk = 0;
  logic rstN = 0;
  logic loadStb = 0, startStb = 0, tick = 0;
  logic signed [15:0] coefIn = 0, seedANew = 0, seedAOld = 0, seedBNew = 0, seedBOld = 0;
  logic signed [15:0] sampleA, sampleB;
  logic sampleValid, running;

  int errors = 0;
  int checks = 0;
  int validCount = 0;

  always #2 clk = ~clk;

  dual_sine_osc u_dual_sine_osc (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .startStb(startStb), .tick(tick),
    .coefIn(coefIn), .seedANew(seedANew), .seedAOld(seedAOld),
    .seedBNew(seedBNew), .seedBOld(seedBOld),
    .sampleA(sampleA), .sampleB(sampleB), .sampleValid(sampleValid), .running(running)
  );

  // reference model
  int mNew[2], mOld[2], mCoef, mBusy;
  bit mRun, mValid;

  function automatic int stepVal(int c, int yn, int yo);
    longint a;
    a = longint'(c) * yn - longint'(yo) * 16384;
    a = (a + 8192) >>> 14;
    if (a > 32767) a = 32767;
    if (a < -32768) a = -32768;
    return int'(a);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mNew = '{0, 0}; mOld = '{0, 0}; mCoef = 0; mBusy = 0; mRun = 0; mValid = 0;
    end else begin
      mValid = 0;
      if (loadStb) begin
        mRun = 0; mBusy = 0; mCoef = coefIn;
        mNew[0] = seedANew; mOld[0] = seedAOld;
        mNew[1] = seedBNew; mOld[1] = seedBOld;
      end else begin
        if (mBusy > 0) begin
          mBusy--;
          if (mBusy == 0) begin
            for (int k = 0; k < 2; k++) begin
              int r;
              r = stepVal(mCoef, mNew[k], mOld[k]);
              mOld[k] = mNew[k];
              mNew[k] = r;
            end
            mValid = 1;
          end
        end else if (tick && mRun) begin
          mBusy = 2;
        end
        if (startStb) mRun = 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R3 sampleA vs model", sampleA, mNew[0]);
      check("R6 sampleB vs model", sampleB, mNew[1]);
      check("R5 valid vs model", sampleValid, mValid);
      check("R7 running vs model", running, mRun);
    end
    if (sampleValid) validCount++;
  end

  task automatic doLoad(int c, int an, int ao, int bn, int bo);
    @(negedge clk);
    coefIn = 16'(c); seedANew = 16'(an); seedAOld = 16'(ao);
    seedBNew = 16'(bn); seedBOld = 16'(bo); loadStb = 1;
    @(negedge clk);
    loadStb = 0;
  endtask

  task automatic doStart();
    @(negedge clk); startStb = 1;
    @(negedge clk); startStb = 0;
  endtask

  // tick, then stop at the negedge where valid is expected high
  task automatic doTick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vc;
    repeat (3) @(negedge clk);
    check("R1 reset sampleA", sampleA, 0);
    check("R1 reset valid", sampleValid, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after reset sampleB", sampleB, 0);
    check("R1 after reset running", running, 0);

    // R2: load shows seeds
    doLoad(16384, 1000, 500, -300, 700);
    check("R2 seed A", sampleA, 1000);
    check("R2 seed B", sampleB, -300);
    check("R2 running low", running, 0);

    // R7: tick before start ignored
    vc = validCount;
    doTick(); @(negedge clk);
    check("R7 no valid before start", validCount - vc, 0);
    check("R7 sample held", sampleA, 1000);

    // R3 / R6: first update
    doStart();
    doTick();
    check("R5 valid at t+2", sampleValid, 1);
    check("R3 first A", sampleA, 500);
    check("R6 first B", sampleB, -1000);
    @(negedge clk);
    check("R5 valid one cycle", sampleValid, 0);

    // R9: history shifts
    doTick();
    check("R9 second A", sampleA, -500);
    check("R9 second B", sampleB, -700);

    // R3: rounding ties
    doLoad(24576, 1, 0, -1, 0);
    doStart(); doTick();
    check("R3 round +1.5", sampleA, 2);
    check("R3 round -1.5", sampleB, -1);

    // R4: saturation
    doLoad(32767, 30000, -30000, -30000, 30000);
    doStart(); doTick();
    check("R4 clamp high", sampleA, 32767);
    check("R4 clamp low", sampleB, -32768);

    // R5: ticks during computation ignored
    doLoad(16384, 100, 0, 200, 0);
    doStart();
    vc = validCount;
    @(negedge clk); tick = 1;
    @(negedge clk);
    @(negedge clk); tick = 0;
    repeat (4) @(negedge clk);
    check("R5 one valid for busy ticks", validCount - vc, 1);
    check("R5 single update A", sampleA, 100);

    // R8: load aborts a computation
    vc = validCount;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    coefIn = 16384; seedANew = 77; seedAOld = 11; seedBNew = -55; seedBOld = 9;
    loadStb = 1; startStb = 1;
    @(negedge clk); loadStb = 0; startStb = 0;
    repeat (3) @(negedge clk);
    check("R8 no valid after abort", validCount - vc, 0);
    check("R8 new seed A", sampleA, 77);
    check("R8 load beats start", running, 0);

    // R10: reference tone, 20 samples per period
    doLoad(31164, 0, -4944, 13856, 10706);
    doStart();
    for (int i = 0; i < 20; i++) doTick();
    checks++;
    if (sampleA > 64 || sampleA < -64) begin
      errors++; $display("FAIL R10 period A: actual=%0d expected=0", sampleA);
    end
    checks++;
    if (sampleB > 13856 + 64 || sampleB < 13856 - 64) begin
      errors++; $display("FAIL R10 period B: actual=%0d expected=13856", sampleB);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule